// File: doc/BRIEF.md
# Operand Swizzle and Write-Mask Unit

This block sits between operand fetch and the vector arithmetic of a shader pipeline. Each decoded vector instruction carries a small descriptor index. The block uses that index to read a 32-bit descriptor word from a table that the host loads ahead of time. It then reorders the four 32-bit lanes of up to three source vectors as that descriptor directs, and can flip the sign of each source. It also turns the descriptor's destination mask into one write enable per lane. Lane data is treated as opaque floating-point words: only the sign bit is ever touched.

Instructions enter through a valid/ready handshake and leave through another, one cycle later. A stage holds its output while `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An input is accepted on a rising edge where `in_valid` and `in_ready` are both high. The host table port is a plain synchronous write port with no handshake. A lane whose write enable is low must leave the destination unchanged. The block expresses this only through `out_wen`.

Top module: `opnd_shape_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_wen` is 0 and `in_ready` is 1.
- R2: An input accepted on a clock edge appears on the outputs with `out_valid` high after exactly that one edge. If nothing new is accepted, a result that is taken (`out_valid` and `out_ready` both high) clears `out_valid` on the next edge.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold their values.
- R4: Source vectors pack lane 0 (x) in bits [31:0], lane 1 (y) in [63:32], lane 2 (z) in [95:64] and lane 3 (w) in [127:96]. Output lane k takes the input lane named by selector bits [7-2k:6-2k], where code 0 is x, 1 is y, 2 is z and 3 is w. Selector 0x1B is the identity, 0x55 copies y to every lane, and 0xE4 reverses the lanes.
- R5: In the descriptor, source 1 uses selector bits [12:5] and negate bit 4, source 2 uses selector bits [21:14] and negate bit 13, and source 3 uses selector bits [30:23] and negate bit 22. Each source is shaped only by its own fields.
- R6: A set negate bit inverts bit 31 of every lane of that source after the lane reordering and leaves bits [30:0] unchanged.
- R7: Descriptor bits [3:0] form the destination mask, with bit 3 for x, bit 2 for y, bit 1 for z and bit 0 for w. `out_wen[k]` is the enable for lane k, so `out_wen` = {mask[0], mask[1], mask[2], mask[3]}.
- R8: A host write with `tbl_we` high stores `tbl_wdata` at `tbl_addr` on the clock edge. An instruction accepted on that same edge uses the previous contents of the table. Later instructions use the new word.
- R9: With `in_short_id` high, only `in_id[4:0]` selects the descriptor and bits [6:5] are ignored. With `in_short_id` low, all 7 bits select it.
- R10: `out_wen` is 0 in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Host table write strobe |
| tbl_addr | input | 7 | Host table word address |
| tbl_wdata | input | 32 | Host descriptor word |
| in_valid | input | 1 | Instruction operands valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_id | input | 7 | Descriptor index |
| in_short_id | input | 1 | Index uses only its low 5 bits |
| in_src1 | input | 128 | Raw source 1 vector |
| in_src2 | input | 128 | Raw source 2 vector |
| in_src3 | input | 128 | Raw source 3 vector |
| out_valid | output | 1 | Shaped operands valid |
| out_ready | input | 1 | Consumer accepts shaped operands |
| out_src1 | output | 128 | Shaped source 1 |
| out_src2 | output | 128 | Shaped source 2 |
| out_src3 | output | 128 | Shaped source 3 |
| out_wen | output | 4 | Per-lane destination write enables, bit k for lane k |

## Verification
The assertions watch the handshake on every cycle. They cover the one-edge latency from accept to valid and the drop of `out_valid` after a drain. They also check the frozen outputs and low `in_ready` during a stall, the zero write enables while idle, and that each table write actually lands. An immediate check in the lane shuffler confirms that the identity selector passes a vector through untouched. The bench scenarios are what show the data content: correct lane codes, the descriptor field positions of each source, the sign flip, the reversed mask order, index truncation in short mode, and the old-word rule when a write and a lookup share an edge.

// File: rtl/opshape_pkg.sv
package opshape_pkg;
  localparam int LANES  = 4;
  localparam int SEL_W  = 8;
  localparam int CODE_W = 2;
  localparam int NSRC   = 3;

  typedef struct packed {
    logic             spare;
    logic [SEL_W-1:0] sel3;
    logic             neg3;
    logic [SEL_W-1:0] sel2;
    logic             neg2;
    logic [SEL_W-1:0] sel1;
    logic             neg1;
    logic [LANES-1:0] wmask;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);
endpackage

// File: rtl/opshape_desc_table.sv
module opshape_desc_table #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/opshape_lane_shuffle.sv
module opshape_lane_shuffle
  import opshape_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [LANES*LANE_W-1:0] vec_in,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    neg,
  output logic [LANES*LANE_W-1:0] vec_out
);
  localparam logic [SEL_W-1:0] IDENT_SEL = 8'h1B;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CODE_W-1:0] code;
    logic [LANE_W-1:0] picked;
    assign code   = sel[SEL_W-1-CODE_W*k -: CODE_W];
    assign picked = vec_in[code*LANE_W +: LANE_W];
    assign vec_out[k*LANE_W +: LANE_W] =
      {picked[LANE_W-1] ^ neg, picked[LANE_W-2:0]};
  end

  always_comb begin
    if (sel == IDENT_SEL && !neg) begin
      a_identity_pass_r4: assert (vec_out == vec_in);
    end
  end
endmodule

// File: rtl/opnd_shape_unit.sv
module opnd_shape_unit
  import opshape_pkg::*;
#(
  parameter int LANE_W     = 32,
  parameter int ID_W       = 7,
  parameter int SHORT_ID_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tbl_we,
  input  logic [ID_W-1:0]         tbl_addr,
  input  logic [DESC_W-1:0]       tbl_wdata,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ID_W-1:0]         in_id,
  input  logic                    in_short_id,
  input  logic [LANES*LANE_W-1:0] in_src1,
  input  logic [LANES*LANE_W-1:0] in_src2,
  input  logic [LANES*LANE_W-1:0] in_src3,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_src1,
  output logic [LANES*LANE_W-1:0] out_src2,
  output logic [LANES*LANE_W-1:0] out_src3,
  output logic [LANES-1:0]        out_wen
);
  localparam int VEC_W = LANES * LANE_W;

  logic [ID_W-1:0]   id_eff;
  logic [DESC_W-1:0] desc_word;
  desc_t             desc;
  logic [VEC_W-1:0]  raw    [NSRC];
  logic [VEC_W-1:0]  shaped [NSRC];
  logic [SEL_W-1:0]  sel_of [NSRC];
  logic              neg_of [NSRC];
  logic [LANES-1:0]  wen_next;
  logic [VEC_W-1:0]  res_q  [NSRC];

  assign id_eff = in_short_id
                ? {{(ID_W-SHORT_ID_W){1'b0}}, in_id[SHORT_ID_W-1:0]}
                : in_id;

  opshape_desc_table #(.ADDR_W(ID_W), .WORD_W(DESC_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (id_eff),
    .rdata (desc_word)
  );

  assign desc   = desc_t'(desc_word);
  assign raw[0] = in_src1;
  assign raw[1] = in_src2;
  assign raw[2] = in_src3;

  always_comb begin
    sel_of[0] = desc.sel1;  neg_of[0] = desc.neg1;
    sel_of[1] = desc.sel2;  neg_of[1] = desc.neg2;
    sel_of[2] = desc.sel3;  neg_of[2] = desc.neg3;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    opshape_lane_shuffle #(.LANE_W(LANE_W)) u_shuffle (
      .vec_in  (raw[s]),
      .sel     (sel_of[s]),
      .neg     (neg_of[s]),
      .vec_out (shaped[s])
    );
  end

  // mask bit 3 belongs to lane 0 (x), bit 0 to lane 3 (w)
  for (genvar k = 0; k < LANES; k++) begin : g_wen
    assign wen_next[k] = desc.wmask[LANES-1-k];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wen   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      out_wen   <= in_valid ? wen_next : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      for (int s = 0; s < NSRC; s++) res_q[s] <= shaped[s];
    end
  end

  assign out_src1 = res_q[0];
  assign out_src2 = res_q[1];
  assign out_src3 = res_q[2];

  p_accept_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_stall_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_src1) &&
      $stable(out_src2) && $stable(out_src3) && $stable(out_wen)));

  p_idle_no_wen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_wen == '0));
endmodule

// File: tb/tb_opnd_shape_unit.sv
module tb_opnd_shape_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tbl_we;
  logic [6:0]   tbl_addr;
  logic [31:0]  tbl_wdata;
  logic         in_valid;
  logic         in_ready;
  logic [6:0]   in_id;
  logic         in_short_id;
  logic [127:0] in_src1, in_src2, in_src3;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_src1, out_src2, out_src3;
  logic [3:0]   out_wen;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  opnd_shape_unit dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_short_id(in_short_id), .in_src1(in_src1),
    .in_src2(in_src2), .in_src3(in_src3), .out_valid(out_valid),
    .out_ready(out_ready), .out_src1(out_src1), .out_src2(out_src2),
    .out_src3(out_src3), .out_wen(out_wen)
  );

  localparam logic [127:0] VA = {32'h4080_0000, 32'hC040_0000, 32'h4000_0000, 32'h3F80_0000};
  localparam logic [127:0] VB = {32'hBF00_0000, 32'h4120_0000, 32'h8000_0000, 32'h4248_0000};
  localparam logic [127:0] VC = {32'h1111_1111, 32'hA222_2222, 32'h3333_3333, 32'hC444_4444};

  function automatic logic [31:0] mkdesc(input logic [3:0] m,
      input logic n1, input logic [7:0] s1, input logic n2, input logic [7:0] s2,
      input logic n3, input logic [7:0] s3);
    return {1'b0, s3, n3, s2, n2, s1, n1, m};
  endfunction

  function automatic logic [127:0] model(input logic [127:0] v,
      input logic [7:0] sel, input logic neg);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [1:0]  c;
      logic [31:0] w;
      c = sel[7-2*k -: 2];
      w = v[c*32 +: 32];
      w[31] = w[31] ^ neg;
      r[k*32 +: 32] = w;
    end
    return r;
  endfunction

  function automatic logic [3:0] wen_of(input logic [3:0] m);
    return {m[0], m[1], m[2], m[3]};
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic twrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // drives one instruction, leaves outputs valid at the returning negedge
  task automatic issue(input logic [6:0] id, input logic sh,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_id = id; in_short_id = sh;
    in_src1 = a; in_src2 = b; in_src3 = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_desc(input string req, input logic [31:0] d,
      input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    chk({req, " valid"}, 128'(out_valid), 128'(1'b1));
    chk({req, " src1"}, out_src1, model(a, d[12:5], d[4]));
    chk({req, " src2"}, out_src2, model(b, d[21:14], d[13]));
    chk({req, " src3"}, out_src3, model(c, d[30:23], d[22]));
    chk({req, " wen"}, 128'(out_wen), 128'(wen_of(d[3:0])));
  endtask

  task automatic t_reset;
    chk("R1 out_valid", 128'(out_valid), 128'(0));
    chk("R1 out_wen", 128'(out_wen), 128'(0));
    chk("R1 in_ready", 128'(in_ready), 128'(1));
  endtask

  task automatic t_identity;
    logic [31:0] d = mkdesc(4'hF, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B);
    twrite(7'd3, d);
    issue(7'd3, 0, VA, VB, VC);
    chk("R4 identity", out_src1, VA);
    expect_desc("R4", d, VA, VB, VC);
  endtask

  task automatic t_fields;
    logic [31:0] d = mkdesc(4'b1010, 0, 8'h55, 0, 8'hE4, 0, 8'hAA);
    twrite(7'd10, d);
    issue(7'd10, 0, VA, VB, VC);
    chk("R4 yyyy", out_src1, {4{VA[63:32]}});
    chk("R4 reverse", out_src2, {VB[31:0], VB[63:32], VB[95:64], VB[127:96]});
    expect_desc("R5", d, VA, VB, VC);
  endtask

  task automatic t_negate;
    logic [31:0] d = mkdesc(4'b0001, 1, 8'h1B, 0, 8'h1B, 1, 8'h27);
    twrite(7'd99, d);
    issue(7'd99, 0, VA, VB, VC);
    chk("R6 neg src1", out_src1, VA ^ {4{32'h8000_0000}});
    chk("R6 plain src2", out_src2, VB);
    expect_desc("R6", d, VA, VB, VC);
  endtask

  task automatic t_mask;
    logic [31:0] d1 = mkdesc(4'b1000, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B);
    logic [31:0] d2 = mkdesc(4'b0011, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B);
    twrite(7'd20, d1);
    twrite(7'd21, d2);
    issue(7'd20, 0, VA, VB, VC);
    chk("R7 x only", 128'(out_wen), 128'(4'b0001));
    issue(7'd21, 0, VA, VB, VC);
    chk("R7 z w", 128'(out_wen), 128'(4'b1100));
  endtask

  task automatic t_short;
    logic [31:0] dlo = mkdesc(4'b0100, 0, 8'hFF, 0, 8'h00, 0, 8'h1B);
    logic [31:0] dhi = mkdesc(4'b0010, 1, 8'h00, 1, 8'hFF, 1, 8'h55);
    twrite(7'h05, dlo);
    twrite(7'h65, dhi);
    issue(7'h65, 1, VA, VB, VC);
    expect_desc("R9 short", dlo, VA, VB, VC);
    issue(7'h65, 0, VA, VB, VC);
    expect_desc("R9 long", dhi, VA, VB, VC);
  endtask

  task automatic t_stall;
    logic [31:0] da = mkdesc(4'b1111, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B);
    logic [31:0] db = mkdesc(4'b0110, 1, 8'h55, 0, 8'hE4, 1, 8'h00);
    twrite(7'd40, da);
    twrite(7'd41, db);
    out_ready = 1'b0;
    issue(7'd40, 0, VA, VB, VC);
    chk("R3 stall in_ready", 128'(in_ready), 128'(0));
    in_valid = 1'b1; in_id = 7'd41; in_short_id = 0;
    in_src1 = VC; in_src2 = VA; in_src3 = VB;
    repeat (2) @(negedge clk);
    expect_desc("R3 held", da, VA, VB, VC);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_desc("R3 next", db, VC, VA, VB);
    @(negedge clk);
    chk("R2 drained", 128'(out_valid), 128'(0));
    chk("R10 idle wen", 128'(out_wen), 128'(0));
  endtask

  task automatic t_collide;
    logic [31:0] dold = mkdesc(4'b1001, 0, 8'h1B, 0, 8'h1B, 0, 8'h1B);
    logic [31:0] dnew = mkdesc(4'b0110, 1, 8'hE4, 1, 8'hE4, 1, 8'hE4);
    twrite(7'd127, dold);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 7'd127; tbl_wdata = dnew;
    in_valid = 1'b1; in_id = 7'd127; in_short_id = 0;
    in_src1 = VA; in_src2 = VB; in_src3 = VC;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0; in_valid = 1'b0;
    expect_desc("R8 old word", dold, VA, VB, VC);
    issue(7'd127, 0, VA, VB, VC);
    expect_desc("R8 new word", dnew, VA, VB, VC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tbl_we = 0; tbl_addr = '0; tbl_wdata = '0;
    in_valid = 0; in_id = '0; in_short_id = 0;
    in_src1 = '0; in_src2 = '0; in_src3 = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_identity();
    t_fields();
    t_negate();
    t_mask();
    t_short();
    t_stall();
    t_collide();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule